// File: doc/BRIEF.md
# Type B Card Response Framer

This block turns a buffered response into the serial sample stream that a proximity card returns to a reader. Software or an upstream engine first places a frame length on the length input and pulses start. The frame bytes, with the CRC already appended, then arrive through a byte-wide valid/ready port. The framer emits one output sample on each clock enable. Every logical bit lasts four samples.

A frame has four parts, in this order. First comes a long run of logic one so that the reader can lock its phase. Next comes a start-of-frame mark. Then each byte follows as an asynchronous character. The frame closes with an end-of-frame mark, which has the same shape as the start mark. Busy stays high from the first preamble sample through the last end-mark sample, and the line then rests high. A one-byte holding slot fetches the next byte while the current character is being sent, so characters follow one another with no gap.

Top module: `tbf_framer`

## Requirements
- R1: After reset and between frames, `tx_o` is 1, `busy_o` is 0 and `byte_ready_o` is 0.
- R2: A start pulse is accepted only while `busy_o` is 0. A start pulse during a frame changes neither the output stream nor the number of bytes fetched.
- R3: Every logical bit is sent as exactly four consecutive identical samples.
- R4: A frame opens with 20 bit times of logic 1.
- R5: The start-of-frame mark is 10 bit times of 0 followed by 2 bit times of 1.
- R6: Each byte is sent as one character: a start bit of 0, then the eight data bits with bit 0 first, then a stop bit of 1.
- R7: While a byte is waiting in the slot, the start bit of the next character follows the stop bit of the previous one directly, with no extra bit time.
- R8: The end-of-frame mark is 10 bit times of 0 followed by 2 bit times of 1, after which the block returns to idle.
- R9: A length of 0 produces the preamble, the start mark and the end mark, with no characters between them.
- R10: `busy_o` rises on the clock after start is accepted. It falls on the clock edge that consumes the last end-mark sample.
- R11: `byte_ready_o` is high only during a frame. Exactly as many bytes are taken as the accepted length.
- R12: The output moves to the next sample only on a clock where `smp_en` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample-rate enable; advances the output by one sample |
| start_i | input | 1 | Frame request, taken while idle |
| len_i | input | LEN_W | Number of bytes in the frame, sampled with start |
| byte_valid_i | input | 1 | Byte offered on `byte_data_i` |
| byte_data_i | input | 8 | Frame byte, CRC included |
| byte_ready_o | output | 1 | Slot can take a byte this cycle |
| busy_o | output | 1 | Frame in progress |
| tx_o | output | 1 | Serial output sample |

## Verification
The bench builds the block with its default parameters: four samples per bit, a 20-bit preamble, marks of 10 low and 2 high bits, and an 8-bit length. With these values a complete frame is only a few hundred samples long. That size puts full frames, a zero-length frame and a start pulse issued mid-frame all within a short run. The frames are driven with the enable high on every cycle, high on every third cycle, and toggled at random. Driving them this way checks that sample boundaries follow the enable and not the clock.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOFL,
        ST_SOFH,
        ST_CHAR,
        ST_WAIT,
        ST_EOFL,
        ST_EOFH
    } tbf_state_e;
endpackage

// File: rtl/tbf_slot.sv
module tbf_slot #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             take_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    output logic             byte_ready_o,
    output logic             full_o,
    output logic [7:0]       data_o
);
    typedef struct packed {
        logic             full;
        logic [7:0]       data;
        logic [LEN_W-1:0] pend;
    } slot_s;

    slot_s slot_d, slot_q;

    assign byte_ready_o = !slot_q.full && (slot_q.pend != '0);
    assign full_o       = slot_q.full;
    assign data_o       = slot_q.data;

    always_comb begin
        slot_d = slot_q;
        if (accept_i) begin
            slot_d.pend = len_i;
        end
        if (take_i) begin
            slot_d.full = 1'b0;
        end
        if (byte_ready_o && byte_valid_i) begin
            slot_d.full = 1'b1;
            slot_d.data = byte_data_i;
            slot_d.pend = slot_q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R6: the sequencer only takes a byte that is held
    p_take_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> slot_q.full);
    // R11: a held byte is not overwritten before it is taken
    p_data_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.full && !take_i) |=> $stable(slot_q.data));
endmodule

// File: rtl/tbf_seq.sv
module tbf_seq
    import tbf_pkg::*;
#(
    parameter int SPB       = 4,
    parameter int PRE_BITS  = 20,
    parameter int MARK_LOW  = 10,
    parameter int MARK_HIGH = 2,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             hold_full_i,
    input  logic [7:0]       hold_data_i,
    output logic             take_o,
    output logic             busy_o,
    output logic             tx_o
);
    localparam int CHAR_BITS = 10;
    localparam int SW   = (SPB > 1) ? $clog2(SPB) : 1;
    localparam int MAXC = (PRE_BITS > MARK_LOW) ?
                          ((PRE_BITS > CHAR_BITS) ? PRE_BITS : CHAR_BITS) :
                          ((MARK_LOW > CHAR_BITS) ? MARK_LOW : CHAR_BITS);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        tbf_state_e           state;
        logic [SW-1:0]        smp;
        logic [CW-1:0]        bitc;
        logic [CHAR_BITS-1:0] shreg;
        logic [LEN_W-1:0]     left;
    } seq_s;

    seq_s seq_d, seq_q;
    logic bit_end;
    logic go_next;

    assign bit_end = smp_en && (seq_q.smp == SW'(SPB - 1));

    always_comb begin
        seq_d   = seq_q;
        take_o  = 1'b0;
        go_next = 1'b0;
        if (seq_q.state != ST_IDLE && seq_q.state != ST_WAIT && smp_en) begin
            seq_d.smp = bit_end ? '0 : seq_q.smp + 1'b1;
        end
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_PRE;
                    seq_d.smp   = '0;
                    seq_d.bitc  = '0;
                    seq_d.left  = len_i;
                end
            end
            ST_PRE: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(PRE_BITS - 1)) begin
                        seq_d.state = ST_SOFL;
                        seq_d.bitc  = '0;
                    end else begin
                        seq_d.bitc = seq_q.bitc + 1'b1;
                    end
                end
            end
            ST_SOFL: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(MARK_LOW - 1)) begin
                        seq_d.state = ST_SOFH;
                        seq_d.bitc  = '0;
                    end else begin
                        seq_d.bitc = seq_q.bitc + 1'b1;
                    end
                end
            end
            ST_SOFH: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(MARK_HIGH - 1)) go_next = 1'b1;
                    else seq_d.bitc = seq_q.bitc + 1'b1;
                end
            end
            ST_CHAR: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(CHAR_BITS - 1)) begin
                        go_next = 1'b1;
                    end else begin
                        seq_d.bitc  = seq_q.bitc + 1'b1;
                        seq_d.shreg = seq_q.shreg >> 1;
                    end
                end
            end
            ST_WAIT: begin
                if (smp_en && hold_full_i) begin
                    seq_d.state = ST_CHAR;
                    seq_d.smp   = '0;
                    seq_d.bitc  = '0;
                    seq_d.shreg = {1'b1, hold_data_i, 1'b0};
                    seq_d.left  = seq_q.left - 1'b1;
                    take_o      = 1'b1;
                end
            end
            ST_EOFL: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(MARK_LOW - 1)) begin
                        seq_d.state = ST_EOFH;
                        seq_d.bitc  = '0;
                    end else begin
                        seq_d.bitc = seq_q.bitc + 1'b1;
                    end
                end
            end
            ST_EOFH: begin
                if (bit_end) begin
                    if (seq_q.bitc == CW'(MARK_HIGH - 1)) begin
                        seq_d.state = ST_IDLE;
                        seq_d.bitc  = '0;
                    end else begin
                        seq_d.bitc = seq_q.bitc + 1'b1;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
        if (go_next) begin
            seq_d.bitc = '0;
            if (seq_q.left == '0) begin
                seq_d.state = ST_EOFL;
            end else if (hold_full_i) begin
                seq_d.state = ST_CHAR;
                seq_d.shreg = {1'b1, hold_data_i, 1'b0};
                seq_d.left  = seq_q.left - 1'b1;
                take_o      = 1'b1;
            end else begin
                seq_d.state = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        case (seq_q.state)
            ST_SOFL, ST_EOFL: tx_o = 1'b0;
            ST_CHAR:          tx_o = seq_q.shreg[0];
            default:          tx_o = 1'b1;
        endcase
    end
    assign busy_o = (seq_q.state != ST_IDLE);

    // R2: a start pulse mid-frame leaves the character count alone
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !take_o) |=> (seq_q.left == $past(seq_q.left)));
    // R12: no sample advance without the enable
    p_hold_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !smp_en) |=> $stable(tx_o));
    // R8: the frame ends only from the high part of the end mark
    p_end_from_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(seq_q.state) == ST_EOFH));
    // R7: a character is loaded only from a full slot
    p_take_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> hold_full_i);
endmodule

// File: rtl/tbf_framer.sv
module tbf_framer #(
    parameter int SPB       = 4,
    parameter int PRE_BITS  = 20,
    parameter int MARK_LOW  = 10,
    parameter int MARK_HIGH = 2,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    output logic             byte_ready_o,
    output logic             busy_o,
    output logic             tx_o
);
    logic       accept;
    logic       take;
    logic       hold_full;
    logic [7:0] hold_data;

    assign accept = start_i && !busy_o;

    tbf_slot #(.LEN_W(LEN_W)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .len_i        (len_i),
        .take_i       (take),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .byte_ready_o (byte_ready_o),
        .full_o       (hold_full),
        .data_o       (hold_data)
    );

    tbf_seq #(
        .SPB       (SPB),
        .PRE_BITS  (PRE_BITS),
        .MARK_LOW  (MARK_LOW),
        .MARK_HIGH (MARK_HIGH),
        .LEN_W     (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_en      (smp_en),
        .start_i     (start_i),
        .len_i       (len_i),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .take_o      (take),
        .busy_o      (busy_o),
        .tx_o        (tx_o)
    );

    // R11: bytes are requested only inside a frame
    p_ready_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> busy_o);
    // R10: an accepted start raises busy on the next clock
    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
endmodule

// File: tb/tbf_framer_bench.sv
module tbf_framer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] len_i = '0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_ready_o, busy_o, tx_o;

    int n_checks = 0;
    int n_fail = 0;
    int en_mode = 0;
    int en_cnt = 0;
    int cycles = 0;
    int taken = 0;

    logic [7:0] frame_bytes[$];
    logic [7:0] feed_q[$];
    logic       exp_bits[$];
    string      exp_tag[$];
    bit         m_busy = 1'b0;
    int         m_idx = 0;

    always #2.5 clk = ~clk;

    tbf_framer u_tbf_framer (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .start_i(start_i),
        .len_i(len_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_ready_o(byte_ready_o), .busy_o(busy_o), .tx_o(tx_o)
    );

    task automatic add_bits(input logic v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_bits.push_back(v);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic build_frame();
        exp_bits.delete();
        exp_tag.delete();
        add_bits(1'b1, 20, "R4 preamble");
        add_bits(1'b0, 10, "R5 sof low");
        add_bits(1'b1, 2,  "R5 sof high");
        for (int b = 0; b < frame_bytes.size(); b++) begin
            add_bits(1'b0, 1, (b == 0) ? "R6 start bit" : "R7 next start bit");
            for (int k = 0; k < 8; k++) add_bits(frame_bytes[b][k], 1, "R6 data bit");
            add_bits(1'b1, 1, "R6 stop bit");
        end
        add_bits(1'b0, 10, (frame_bytes.size() == 0) ? "R9 eof low" : "R8 eof low");
        add_bits(1'b1, 2,  "R8 eof high");
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced at the active edge
    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (byte_valid_i && byte_ready_o) begin
                taken++;
                void'(feed_q.pop_front());
            end
            if (m_busy && smp_en) begin
                m_idx++;
                if (m_idx == exp_bits.size() * 4) m_busy = 1'b0;
            end else if (!m_busy && start_i) begin
                build_frame();
                m_busy = 1'b1;
                m_idx  = 0;
            end
        end
    end

    // compare and drive away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy_o == m_busy, "R10 busy", busy_o, m_busy);
            if (m_busy)
                check(tx_o == exp_bits[m_idx / 4], {"R3 ", exp_tag[m_idx / 4]},
                      tx_o, exp_bits[m_idx / 4]);
            else
                check(tx_o == 1'b1, "R1 idle line", tx_o, 1);
        end
        byte_valid_i <= (feed_q.size() > 0);
        byte_data_i  <= (feed_q.size() > 0) ? feed_q[0] : 8'h00;
        en_cnt++;
        case (en_mode)
            0:       smp_en <= 1'b1;
            1:       smp_en <= (en_cnt % 3 == 0);
            default: smp_en <= 1'($urandom % 2);
        endcase
    end

    task automatic run_frame(input int mode, input bit late_start);
        en_mode = mode;
        taken = 0;
        feed_q = frame_bytes;
        @(negedge clk);
        start_i = 1'b1;
        len_i   = 8'(frame_bytes.size());
        @(negedge clk);
        start_i = 1'b0;
        if (late_start) begin
            repeat (60) @(negedge clk);
            start_i = 1'b1;          // R2: must be ignored
            len_i   = 8'd5;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (m_busy) @(negedge clk);
        @(negedge clk);
        check(taken == frame_bytes.size(), "R11 bytes taken", taken, frame_bytes.size());
        check(byte_ready_o == 1'b0, "R11 ready low after frame", byte_ready_o, 0);
        check(busy_o == 1'b0 && tx_o == 1'b1, "R1 idle after frame", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tx_o == 1'b1 && busy_o == 1'b0 && byte_ready_o == 1'b0,
              "R1 reset state", {tx_o, busy_o, byte_ready_o}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        frame_bytes = '{8'h50, 8'h82, 8'hA5};
        run_frame(0, 1'b0);
        frame_bytes.delete();          // R9: empty frame
        run_frame(1, 1'b0);
        frame_bytes = '{8'h00, 8'hFF};
        run_frame(2, 1'b1);            // R2, R12: random enable, late start
        frame_bytes = '{8'h3C};
        run_frame(0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0 cycles overrun", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule